// File: doc/BRIEF.md
# Windowed Register File Controller

This block holds a physical register file of `NAREG` 32-bit registers and shows software a sliding view of sixteen of them. The view starts at four times a window base pointer and wraps around the end of the file. The block also holds a bitmap with one bit per four-register group. Each set bit marks a group that opens a live call frame. The base pointer is always taken modulo `NAREG/4`.

Five operations arrive on one valid/ready port: plain register write, window-call entry, windowed return, explicit window rotate and the stack-pointer-move check. The processor's status flags come in as inputs: window-overflow enable, exception mode and the pending call increment. The block checks each operation against the bitmap and the flags. It then updates the window or reports one event to the exception unit: illegal operation, overflow by 4, 8 or 12 registers, underflow by 4, 8 or 12 registers, or alloca. With each event it gives the old base and the PC that the exception unit should save. A legal return also yields the return PC. The return PC keeps the top two bits of the current PC and takes the low 30 bits from logical register 0. The top two bits of register 0 carry the call increment.

Top module: `wrf_ctrl`

## Requirements
- R1: After reset the window base is 0, only bitmap bit 0 is set, every register reads 0, no event is pending, and `op_ready` is 1 one cycle after reset is released.
- R2: Logical register n (0..15) reads from physical index (base*4 + n) mod NAREG, with no clock delay. A write (op code 0, `op_reg` = logical index) updates the register at the next clock edge.
- R3: Entry (op code 1) is illegal if `op_reg` > 3, if `ps_woe` is 0 or if `ps_excm` is 1. It then reports event code 1 and changes neither the base nor the bitmap.
- R4: A legal entry with call increment c (`ps_callinc`), where none of the c bitmap bits above the base is set, writes a[s] - imm*8 into logical register c*4+s of the old window. It then advances the base by c and sets the bitmap bit at the new base.
- R5: If any of those c bits is set, entry reports overflow. Let d be the distance from base+1 to the first set bit. The base advances by d+1. The event code is 2 if the next set bit follows at once, 3 if one group lies between, and 4 otherwise.
- R6: On every overflow or underflow event, `evt_owb` carries the base from before the operation and `evt_pc` carries `op_pc`.
- R7: Return (op code 2) takes n = a0[31:30]. m is the nearest set bitmap bit at base-1, base-2 or base-3 (1, 2 or 3; 0 if none). The return is illegal (code 1, no state change, no return PC) if n = 0, if m != 0 and m != n, if `ps_woe` is 0 or if `ps_excm` is 1.
- R8: A legal return pulses `ret_valid`, with `ret_pc` = {op_pc[31:30], a0[29:0]}, and moves the base back by n. If the bitmap bit at the new base is set, it clears the bit of the old base.
- R9: If the bitmap bit at the new base is clear after a return, the event code is 5, 6 or 7 for n = 1, 2 or 3, and the bitmap is left unchanged.
- R10: Rotate (op code 3) adds `op_reg`, taken as a signed 4-bit value, to the base modulo NAREG/4.
- R11: The stack-pointer-move check (op code 4) reports event code 8 when the bitmap bits at base-1, base-2 and base-3 are all clear. Otherwise it reports nothing.
- R12: One operation is taken per cycle. `evt_valid` and `ret_valid` pulse only in the cycle after an accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation can be taken |
| op_code | input | 3 | 0 write, 1 entry, 2 return, 3 rotate, 4 stack-pointer check |
| op_reg | input | 4 | Write target, entry source register, or rotate amount |
| op_imm | input | 12 | Entry frame size in 8-byte units |
| op_data | input | 32 | Write data |
| op_pc | input | 32 | PC of the operation |
| ps_woe | input | 1 | Window overflow enable flag |
| ps_excm | input | 1 | Exception mode flag |
| ps_callinc | input | 2 | Pending call increment |
| rd_idx | input | 4 | Logical read index |
| rd_data | output | 32 | Read data |
| wb_o | output | WBW | Current window base |
| ws_o | output | NAREG/4 | Current frame bitmap |
| evt_valid | output | 1 | Event pulse |
| evt_code | output | 4 | Event code |
| evt_owb | output | WBW | Base before the operation |
| evt_pc | output | 32 | PC to save for the event |
| ret_valid | output | 1 | Return PC pulse |
| ret_pc | output | 32 | Return PC |

## Verification
The bench builds the block with NAREG = 32, the smallest legal file, which gives eight groups and a 3-bit base. With so few groups, a short chain of entries wraps the base past the top of the file. That puts the overflow checks against bit 0, all three overflow classes and the physical index wrap of a15 within a handful of operations. Rotating the base to a spot with no frame below it makes the underflow path, the m = 0 case and the alloca case reachable without any spill software.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    typedef enum logic [2:0] {
        OP_WRITE = 3'd0,
        OP_ENTRY = 3'd1,
        OP_RETW  = 3'd2,
        OP_ROTW  = 3'd3,
        OP_MOVSP = 3'd4
    } wrf_op_e;

    typedef enum logic [3:0] {
        EV_NONE    = 4'd0,
        EV_ILLEGAL = 4'd1,
        EV_OVF4    = 4'd2,
        EV_OVF8    = 4'd3,
        EV_OVF12   = 4'd4,
        EV_UNF4    = 4'd5,
        EV_UNF8    = 4'd6,
        EV_UNF12   = 4'd7,
        EV_ALLOCA  = 4'd8
    } wrf_evt_e;
endpackage

// File: rtl/wrf_phys_map.sv
// Logical-to-physical register index: (base*4 + n) mod NAREG.
module wrf_phys_map #(
    parameter int NAREG = 64,
    localparam int PW  = $clog2(NAREG),
    localparam int WBW = PW - 2
) (
    input  logic [WBW-1:0] wb,
    input  logic [3:0]     lidx,
    output logic [PW-1:0]  pidx
);
    // Power-of-two file: truncation performs the wrap.
    assign pidx = {wb, 2'b00} + PW'(lidx);
endmodule

// File: rtl/wrf_ws_scan.sv
// Looks at the frame bitmap around the current base.
module wrf_ws_scan #(
    parameter int NGRP = 16,
    localparam int WBW = $clog2(NGRP)
) (
    input  logic [NGRP-1:0] ws,
    input  logic [WBW-1:0]  wb,
    input  logic [1:0]      callinc,
    output logic            ovf_hit,
    output logic [1:0]      ovf_step,
    output logic [1:0]      ovf_cls,
    output logic [1:0]      ret_m,
    output logic            alloca
);
    logic [4:0] ahead;
    logic [3:1] behind;
    logic [2:0] cmask;

    always_comb begin
        for (int k = 0; k < 5; k++) begin
            ahead[k] = ws[wb + WBW'(k + 1)];
        end
        for (int k = 1; k < 4; k++) begin
            behind[k] = ws[wb - WBW'(k)];
        end
        case (callinc)
            2'd0:    cmask = 3'b000;
            2'd1:    cmask = 3'b001;
            2'd2:    cmask = 3'b011;
            default: cmask = 3'b111;
        endcase
        ovf_hit = |(ahead[2:0] & cmask);

        // Distance to the first live frame, plus one.
        if (ahead[0])      ovf_step = 2'd1;
        else if (ahead[1]) ovf_step = 2'd2;
        else               ovf_step = 2'd3;

        // Gap to the following live frame.
        if (ahead[ovf_step])                ovf_cls = 2'd0;
        else if (ahead[3'(ovf_step) + 3'd1]) ovf_cls = 2'd1;
        else                                ovf_cls = 2'd2;

        if (behind[1])      ret_m = 2'd1;
        else if (behind[2]) ret_m = 2'd2;
        else if (behind[3]) ret_m = 2'd3;
        else                ret_m = 2'd0;
        alloca = (behind == 3'b000);
    end
endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
    import wrf_pkg::*;
#(
    parameter int NAREG = 64,
    localparam int NGRP = NAREG / 4,
    localparam int PW   = $clog2(NAREG),
    localparam int WBW  = PW - 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    output logic            op_ready,
    input  logic [2:0]      op_code,
    input  logic [3:0]      op_reg,
    input  logic [11:0]     op_imm,
    input  logic [31:0]     op_data,
    input  logic [31:0]     op_pc,
    input  logic            ps_woe,
    input  logic            ps_excm,
    input  logic [1:0]      ps_callinc,
    input  logic [3:0]      rd_idx,
    output logic [31:0]     rd_data,
    output logic [WBW-1:0]  wb_o,
    output logic [NGRP-1:0] ws_o,
    output logic            evt_valid,
    output logic [3:0]      evt_code,
    output logic [WBW-1:0]  evt_owb,
    output logic [31:0]     evt_pc,
    output logic            ret_valid,
    output logic [31:0]     ret_pc
);
    localparam int NMAP = 4;   // read, op register, entry target, a0

    typedef struct packed {
        logic [NAREG-1:0][31:0] rf;
        logic [WBW-1:0]         wb;
        logic [NGRP-1:0]        ws;
        logic                   ready;
        logic                   evt_valid;
        wrf_evt_e               evt_code;
        logic [WBW-1:0]         evt_owb;
        logic [31:0]            evt_pc;
        logic                   ret_valid;
        logic [31:0]            ret_pc;
    } st_t;

    st_t st_d, st_q;

    logic [3:0]    map_l [NMAP];
    logic [PW-1:0] map_p [NMAP];

    assign map_l[0] = rd_idx;
    assign map_l[1] = op_reg;
    assign map_l[2] = {ps_callinc, op_reg[1:0]};
    assign map_l[3] = 4'd0;

    for (genvar g = 0; g < NMAP; g++) begin : g_map
        wrf_phys_map #(.NAREG(NAREG)) u_map (
            .wb   (st_q.wb),
            .lidx (map_l[g]),
            .pidx (map_p[g])
        );
    end

    logic       ovf_hit, alloca;
    logic [1:0] ovf_step, ovf_cls, ret_m;

    wrf_ws_scan #(.NGRP(NGRP)) u_scan (
        .ws       (st_q.ws),
        .wb       (st_q.wb),
        .callinc  (ps_callinc),
        .ovf_hit  (ovf_hit),
        .ovf_step (ovf_step),
        .ovf_cls  (ovf_cls),
        .ret_m    (ret_m),
        .alloca   (alloca)
    );

    logic [31:0]    a0_val;
    logic [1:0]     ret_n;
    logic [WBW-1:0] back_wb, ent_wb;
    logic [31:0]    rot_ext;
    logic           mode_bad;

    assign a0_val   = st_q.rf[map_p[3]];
    assign ret_n    = a0_val[31:30];
    assign back_wb  = st_q.wb - WBW'(ret_n);
    assign ent_wb   = st_q.wb + WBW'(ps_callinc);
    assign rot_ext  = {{28{op_reg[3]}}, op_reg};
    assign mode_bad = !ps_woe || ps_excm;

    always_comb begin
        st_d           = st_q;
        st_d.ready     = 1'b1;
        st_d.evt_valid = 1'b0;
        st_d.evt_code  = EV_NONE;
        st_d.ret_valid = 1'b0;
        if (op_valid && st_q.ready) begin
            case (wrf_op_e'(op_code))
                OP_WRITE: begin
                    st_d.rf[map_p[1]] = op_data;
                end
                OP_ENTRY: begin
                    st_d.evt_owb = st_q.wb;
                    st_d.evt_pc  = op_pc;
                    if (op_reg > 4'd3 || mode_bad) begin
                        st_d.evt_valid = 1'b1;
                        st_d.evt_code  = EV_ILLEGAL;
                    end else if (ovf_hit) begin
                        st_d.evt_valid = 1'b1;
                        st_d.wb        = st_q.wb + WBW'(ovf_step);
                        case (ovf_cls)
                            2'd0:    st_d.evt_code = EV_OVF4;
                            2'd1:    st_d.evt_code = EV_OVF8;
                            default: st_d.evt_code = EV_OVF12;
                        endcase
                    end else begin
                        st_d.rf[map_p[2]] = st_q.rf[map_p[1]] - {17'd0, op_imm, 3'b000};
                        st_d.wb           = ent_wb;
                        st_d.ws[ent_wb]   = 1'b1;
                    end
                end
                OP_RETW: begin
                    st_d.evt_owb = st_q.wb;
                    st_d.evt_pc  = op_pc;
                    if (ret_n == 2'd0 || (ret_m != 2'd0 && ret_m != ret_n) || mode_bad) begin
                        st_d.evt_valid = 1'b1;
                        st_d.evt_code  = EV_ILLEGAL;
                    end else begin
                        st_d.ret_valid = 1'b1;
                        st_d.ret_pc    = {op_pc[31:30], a0_val[29:0]};
                        st_d.wb        = back_wb;
                        if (st_q.ws[back_wb]) begin
                            st_d.ws[st_q.wb] = 1'b0;
                        end else begin
                            st_d.evt_valid = 1'b1;
                            case (ret_n)
                                2'd1:    st_d.evt_code = EV_UNF4;
                                2'd2:    st_d.evt_code = EV_UNF8;
                                default: st_d.evt_code = EV_UNF12;
                            endcase
                        end
                    end
                end
                OP_ROTW: begin
                    st_d.wb = st_q.wb + rot_ext[WBW-1:0];
                end
                OP_MOVSP: begin
                    if (alloca) begin
                        st_d.evt_valid = 1'b1;
                        st_d.evt_code  = EV_ALLOCA;
                        st_d.evt_owb   = st_q.wb;
                        st_d.evt_pc    = op_pc;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q           <= '0;
            st_q.ws        <= NGRP'(1);
            st_q.evt_code  <= EV_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_ready  = st_q.ready;
    assign rd_data   = st_q.rf[map_p[0]];
    assign wb_o      = st_q.wb;
    assign ws_o      = st_q.ws;
    assign evt_valid = st_q.evt_valid;
    assign evt_code  = st_q.evt_code;
    assign evt_owb   = st_q.evt_owb;
    assign evt_pc    = st_q.evt_pc;
    assign ret_valid = st_q.ret_valid;
    assign ret_pc    = st_q.ret_pc;
endmodule

// File: rtl/wrf_ctrl_chk.sv
module wrf_ctrl_chk #(
    parameter int NAREG = 64,
    localparam int WBW = $clog2(NAREG) - 2
) (
    input logic           clk,
    input logic           rst,
    input logic           op_valid,
    input logic           op_ready,
    input logic [2:0]     op_code,
    input logic [3:0]     op_reg,
    input logic           ps_excm,
    input logic [WBW-1:0] wb_o,
    input logic           evt_valid,
    input logic [3:0]     evt_code,
    input logic [WBW-1:0] evt_owb,
    input logic           ret_valid
);
    logic           take;
    logic [WBW-1:0] step;

    assign take = op_valid && op_ready;
    assign step = WBW'({{28{op_reg[3]}}, op_reg});

    // R3
    entry_excm_illegal_chk: assert property (@(posedge clk) disable iff (rst)
        take && op_code == 3'd1 && ps_excm |=> evt_valid && evt_code == 4'd1);

    // R10
    rotate_step_chk: assert property (@(posedge clk) disable iff (rst)
        take && op_code == 3'd3 |=> wb_o == $past(wb_o) + $past(step));

    // R11
    alloca_source_chk: assert property (@(posedge clk) disable iff (rst)
        evt_valid && evt_code == 4'd8 |-> $past(take) && $past(op_code) == 3'd4);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> !evt_valid && !ret_valid);

    // R6
    window_evt_owb_chk: assert property (@(posedge clk) disable iff (rst)
        evt_valid && evt_code >= 4'd2 && evt_code <= 4'd7 |-> evt_owb == $past(wb_o));
endmodule

bind wrf_ctrl wrf_ctrl_chk #(.NAREG(NAREG)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_ready  (op_ready),
    .op_code   (op_code),
    .op_reg    (op_reg),
    .ps_excm   (ps_excm),
    .wb_o      (wb_o),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .evt_owb   (evt_owb),
    .ret_valid (ret_valid)
);

// File: tb/wrf_ctrl_tb.sv
module wrf_ctrl_tb;
    localparam int NAREG = 32;
    localparam int WBW   = 3;
    localparam int NGRP  = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            op_valid = 1'b0;
    logic            op_ready;
    logic [2:0]      op_code = '0;
    logic [3:0]      op_reg = '0;
    logic [11:0]     op_imm = '0;
    logic [31:0]     op_data = '0;
    logic [31:0]     op_pc = '0;
    logic            ps_woe = 1'b1;
    logic            ps_excm = 1'b0;
    logic [1:0]      ps_callinc = '0;
    logic [3:0]      rd_idx = '0;
    logic [31:0]     rd_data;
    logic [WBW-1:0]  wb_o;
    logic [NGRP-1:0] ws_o;
    logic            evt_valid;
    logic [3:0]      evt_code;
    logic [WBW-1:0]  evt_owb;
    logic [31:0]     evt_pc;
    logic            ret_valid;
    logic [31:0]     ret_pc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wrf_ctrl #(.NAREG(NAREG)) u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
        .op_code(op_code), .op_reg(op_reg), .op_imm(op_imm), .op_data(op_data),
        .op_pc(op_pc), .ps_woe(ps_woe), .ps_excm(ps_excm), .ps_callinc(ps_callinc),
        .rd_idx(rd_idx), .rd_data(rd_data), .wb_o(wb_o), .ws_o(ws_o),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_owb(evt_owb),
        .evt_pc(evt_pc), .ret_valid(ret_valid), .ret_pc(ret_pc)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [3:0]  rg;
        logic [11:0] imm;
        logic [1:0]  c;
        logic        woe;
        logic        excm;
        logic [2:0]  wb;
        logic [7:0]  ws;
        logic [3:0]  evt;
    } vec_t;

    // Continuous sequence from reset; expected base, bitmap and event code.
    localparam vec_t VECS [12] = '{
        '{4'd11, 3'd4, 4'd0, 12'd0, 2'd0, 1'b1, 1'b0, 3'd0, 8'h01, 4'd8}, // R11 no frame below
        '{4'd4,  3'd1, 4'd1, 12'd0, 2'd1, 1'b1, 1'b0, 3'd1, 8'h03, 4'd0}, // R4
        '{4'd11, 3'd4, 4'd0, 12'd0, 2'd0, 1'b1, 1'b0, 3'd1, 8'h03, 4'd0}, // R11 frame present
        '{4'd4,  3'd1, 4'd1, 12'd0, 2'd2, 1'b1, 1'b0, 3'd3, 8'h0B, 4'd0}, // R4
        '{4'd4,  3'd1, 4'd1, 12'd0, 2'd3, 1'b1, 1'b0, 3'd6, 8'h4B, 4'd0}, // R4
        '{4'd3,  3'd1, 4'd4, 12'd0, 2'd1, 1'b1, 1'b0, 3'd6, 8'h4B, 4'd1}, // R3 reg > 3
        '{4'd3,  3'd1, 4'd1, 12'd0, 2'd1, 1'b0, 1'b0, 3'd6, 8'h4B, 4'd1}, // R3 woe clear
        '{4'd3,  3'd1, 4'd1, 12'd0, 2'd1, 1'b1, 1'b1, 3'd6, 8'h4B, 4'd1}, // R3 excm set
        '{4'd5,  3'd1, 4'd1, 12'd0, 2'd2, 1'b1, 1'b0, 3'd0, 8'h4B, 4'd2}, // R5 overflow-4
        '{4'd10, 3'd3, 4'hE, 12'd0, 2'd0, 1'b1, 1'b0, 3'd6, 8'h4B, 4'd0}, // R10 -2
        '{4'd10, 3'd3, 4'd3, 12'd0, 2'd0, 1'b1, 1'b0, 3'd1, 8'h4B, 4'd0}, // R10 +3
        '{4'd10, 3'd3, 4'd5, 12'd0, 2'd0, 1'b1, 1'b0, 3'd6, 8'h4B, 4'd0}  // R10 +5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        op_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Called at a falling edge; returns one falling edge later with results visible.
    task automatic do_op(input logic [2:0] code, input logic [3:0] rg, input logic [11:0] imm,
                         input logic [31:0] data, input logic [31:0] pc, input logic [1:0] c,
                         input logic woe, input logic excm);
        op_code = code; op_reg = rg; op_imm = imm; op_data = data; op_pc = pc;
        ps_callinc = c; ps_woe = woe; ps_excm = excm; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 base", 32'(wb_o), 32'd0);
        chk("R1 bitmap", 32'(ws_o), 32'h01);
        chk("R1 evt", 32'(evt_valid), 32'd0);
        rd_idx = 4'd7; #1;
        chk("R1 reg", rd_data, 32'd0);
        // R12 ready
        chk("R12 ready", 32'(op_ready), 32'd1);

        foreach (VECS[i]) begin
            do_op(VECS[i].op, VECS[i].rg, VECS[i].imm, 32'd0, 32'h100 + 32'(i),
                  VECS[i].c, VECS[i].woe, VECS[i].excm);
            chk($sformatf("R%0d vec%0d base", VECS[i].req, i), 32'(wb_o), 32'(VECS[i].wb));
            chk($sformatf("R%0d vec%0d bitmap", VECS[i].req, i), 32'(ws_o), 32'(VECS[i].ws));
            chk($sformatf("R%0d vec%0d evt_valid", VECS[i].req, i), 32'(evt_valid),
                32'(VECS[i].evt != 4'd0));
            chk($sformatf("R%0d vec%0d code", VECS[i].req, i), 32'(evt_code), 32'(VECS[i].evt));
        end
        // R12 idle cycle: no pulses
        @(negedge clk);
        chk("R12 idle evt", 32'(evt_valid), 32'd0);

        // R4 entry data path
        do_reset();
        do_op(3'd0, 4'd1, 12'd0, 32'h100, 32'd0, 2'd0, 1'b1, 1'b0);
        do_op(3'd1, 4'd1, 12'd2, 32'd0, 32'd0, 2'd1, 1'b1, 1'b0);
        rd_idx = 4'd1; #1;
        chk("R4 new a1", rd_data, 32'h0000_00F0);

        // R8 legal return
        do_op(3'd0, 4'd0, 12'd0, 32'h4000_1234, 32'd0, 2'd0, 1'b1, 1'b0);
        do_op(3'd2, 4'd0, 12'd0, 32'd0, 32'h8000_0000, 2'd0, 1'b1, 1'b0);
        chk("R8 ret_valid", 32'(ret_valid), 32'd1);
        chk("R8 ret_pc", ret_pc, 32'h8000_1234);
        chk("R8 base", 32'(wb_o), 32'd0);
        chk("R8 bitmap", 32'(ws_o), 32'h01);
        chk("R8 no evt", 32'(evt_valid), 32'd0);

        // R7 n = 0
        do_op(3'd0, 4'd0, 12'd0, 32'h0000_0010, 32'd0, 2'd0, 1'b1, 1'b0);
        do_op(3'd2, 4'd0, 12'd0, 32'd0, 32'h8000_0000, 2'd0, 1'b1, 1'b0);
        chk("R7 n0 code", 32'(evt_code), 32'd1);
        chk("R7 n0 ret", 32'(ret_valid), 32'd0);
        chk("R7 n0 base", 32'(wb_o), 32'd0);

        // R9 underflow-8 with m = 0
        do_op(3'd1, 4'd1, 12'd0, 32'd0, 32'd0, 2'd1, 1'b1, 1'b0);
        do_op(3'd3, 4'd4, 12'd0, 32'd0, 32'd0, 2'd0, 1'b1, 1'b0);
        chk("R10 base 5", 32'(wb_o), 32'd5);
        do_op(3'd0, 4'd0, 12'd0, 32'h8000_0000, 32'd0, 2'd0, 1'b1, 1'b0);
        do_op(3'd2, 4'd0, 12'd0, 32'd0, 32'h4000_0ABC, 2'd0, 1'b1, 1'b0);
        chk("R9 code", 32'(evt_code), 32'd6);
        chk("R6 owb", 32'(evt_owb), 32'd5);
        chk("R6 pc", evt_pc, 32'h4000_0ABC);
        chk("R9 base", 32'(wb_o), 32'd3);
        chk("R9 bitmap", 32'(ws_o), 32'h03);
        chk("R8 ret_pc on underflow", ret_pc, 32'h4000_0000);

        // R7 m = 2 but n = 3
        do_op(3'd0, 4'd0, 12'd0, 32'hC000_0000, 32'd0, 2'd0, 1'b1, 1'b0);
        do_op(3'd2, 4'd0, 12'd0, 32'd0, 32'd0, 2'd0, 1'b1, 1'b0);
        chk("R7 mismatch code", 32'(evt_code), 32'd1);
        chk("R7 mismatch base", 32'(wb_o), 32'd3);

        // R2 physical wrap: a15 at base 7 is a11 at base 0
        do_op(3'd3, 4'd4, 12'd0, 32'd0, 32'd0, 2'd0, 1'b1, 1'b0);
        do_op(3'd0, 4'd15, 12'd0, 32'hDEAD_BEEF, 32'd0, 2'd0, 1'b1, 1'b0);
        do_op(3'd3, 4'd1, 12'd0, 32'd0, 32'd0, 2'd0, 1'b1, 1'b0);
        rd_idx = 4'd11; #1;
        chk("R2 wrap read", rd_data, 32'hDEAD_BEEF);
        chk("R10 base wrap", 32'(wb_o), 32'd0);

        // R5 overflow-12
        do_reset();
        do_op(3'd1, 4'd1, 12'd0, 32'd0, 32'd0, 2'd3, 1'b1, 1'b0);
        do_op(3'd1, 4'd1, 12'd0, 32'd0, 32'd0, 2'd3, 1'b1, 1'b0);
        chk("R4 bitmap 49", 32'(ws_o), 32'h49);
        do_op(3'd1, 4'd1, 12'd0, 32'd0, 32'h0000_1234, 2'd3, 1'b1, 1'b0);
        chk("R5 ovf12 code", 32'(evt_code), 32'd4);
        chk("R5 ovf12 base", 32'(wb_o), 32'd0);
        chk("R6 ovf12 owb", 32'(evt_owb), 32'd6);
        chk("R6 ovf12 pc", evt_pc, 32'h0000_1234);

        // R5 overflow-8
        do_reset();
        do_op(3'd1, 4'd1, 12'd0, 32'd0, 32'd0, 2'd2, 1'b1, 1'b0);
        do_op(3'd1, 4'd1, 12'd0, 32'd0, 32'd0, 2'd2, 1'b1, 1'b0);
        do_op(3'd1, 4'd1, 12'd0, 32'd0, 32'd0, 2'd2, 1'b1, 1'b0);
        chk("R4 bitmap 55", 32'(ws_o), 32'h55);
        do_op(3'd1, 4'd1, 12'd0, 32'd0, 32'd0, 2'd2, 1'b1, 1'b0);
        chk("R5 ovf8 code", 32'(evt_code), 32'd3);
        chk("R5 ovf8 base", 32'(wb_o), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule